// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the lowest layer of an I2C master. An upper sequencer hands it one command at a time (a bus-recovery sweep, a START, a STOP, a byte write, or a byte read with a chosen acknowledge), and the engine turns that command into open-drain activity on SCL and SDA. It returns the acknowledge level it sampled after a write, or the byte it collected during a read. All timing is built from a quarter-bit tick, which an internal divider makes from the system clock. The parameter `QDIV` sets the number of clocks per tick.

Each command is a fixed list of quarter-tick steps. A line change happens only when a step begins. The first step begins on the clock edge that accepts the command, and every later step begins on a tick. The lines are never driven high. Writing a 1 releases a line (its enable goes low), and writing a 0 pulls it low (its enable goes high). `busy` covers the whole command. `done` marks its last clock, and the result outputs then hold until the next command completes.

Top module: `i2c_bit_engine`

## Requirements
- R1: Every step of a command lasts exactly `QDIV` clocks. A line enable changes only on the clock edge that accepts a command or on the edge that ends a quarter tick.
- R2: `cmd_op` is decoded as 1 recover, 2 START, 3 STOP, 4 write, 5 read. With any other code, `cmd_valid` has no effect: `busy` and `done` stay low and both line enables hold.
- R3: A command is accepted when `cmd_valid` is high and `busy` is low. `busy` is high from the next cycle until `done`. A `cmd_valid` seen while `busy` is high is ignored.
- R4: `done` is high for exactly one clock. It rises `QDIV` times this many ticks after the accepting edge: START 4, STOP 4, write 37, read 37, recover 41.
- R5: START releases SDA, then releases SCL, then pulls SDA low while SCL is high. The bus sees one start condition and no stop condition.
- R6: STOP pulls SCL low, then pulls SDA low, then releases SCL, then releases SDA while SCL is high. The bus sees one stop condition.
- R7: A write shifts out `cmd_wdata` MSB first over eight SCL pulses, changing SDA only while SCL is low. It then releases SDA for a ninth pulse and samples SDA two ticks after SCL rises. `ack_out` is 0 for ACK (line low) and 1 for NACK (line high).
- R8: A read releases SDA while SCL is low and samples eight bits MSB first, each one tick after SCL rises, into `rd_data`. On the ninth pulse the master drives `cmd_nack` (0 ACK, 1 NACK) and returns SCL low at the end.
- R9: Recover releases both lines, gives nine SCL pulses with SDA released, and finishes with a full STOP: ten SCL rising edges and one stop condition in total.
- R10: `rd_data` and `ack_out` change only on the clock where `done` is high. The two line enables change on the same clock only when a recover command is accepted.
- R11: After reset both lines are released, `busy` and `done` are low, and `rd_data` and `ack_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 3 | Command code (1 recover, 2 START, 3 STOP, 4 write, 5 read) |
| cmd_wdata | input | BYTE_W | Byte to transmit for a write |
| cmd_nack | input | 1 | Acknowledge level to send after a read (1 = NACK) |
| sda_in | input | 1 | Sampled SDA line level |
| busy | output | 1 | A command is running |
| done | output | 1 | One-clock end-of-command pulse |
| rd_data | output | BYTE_W | Byte collected by the last read |
| ack_out | output | 1 | Acknowledge level sampled by the last write |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
Every result is due a fixed number of clocks after the accepting edge: `QDIV` times 4 for START and STOP, times 37 for a write or a read, and times 41 for recover. The scoreboard stores the clock index of acceptance and compares it with the clock index at which `done` is seen. The bus-level effects (rising-edge count, captured bits, start and stop conditions, the sampled acknowledge) and the result outputs are checked at that same `done` cycle. All sampling happens on the falling clock edge, so each check sees the value registered at the preceding rising edge.

// File: rtl/i2cb_pkg.sv
// Shared types for the I2C bit engine: command codes, step phases, and the
// per-step line action record. Assumes codes not listed are never executed.
package i2cb_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RECOVER = 3'd1,
        OP_START   = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_READ    = 3'd5
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_REL,
        PH_PULSE,
        PH_START,
        PH_STOP,
        PH_WBIT,
        PH_WACK,
        PH_RBIT,
        PH_RACK
    } phase_e;

    typedef struct packed {
        logic set_scl;
        logic scl_v;
        logic set_sda;
        logic sda_v;
    } line_act_t;

    // Line action applied when step 'sub' of phase 'ph' begins.
    function automatic line_act_t step_action(input phase_e ph, input logic [2:0] sub,
                                              input logic dbit, input logic nk);
        line_act_t a;
        a = '{set_scl: 1'b0, scl_v: 1'b1, set_sda: 1'b0, sda_v: 1'b1};
        case (ph)
            PH_REL: begin
                a.set_scl = 1'b1; a.scl_v = 1'b1;
                a.set_sda = 1'b1; a.sda_v = 1'b1;
            end
            PH_PULSE: begin
                if (sub == 3'd0) begin a.set_scl = 1'b1; a.scl_v = 1'b0; end
                if (sub == 3'd2) begin a.set_scl = 1'b1; a.scl_v = 1'b1; end
            end
            PH_START: begin
                if (sub == 3'd1) begin a.set_sda = 1'b1; a.sda_v = 1'b1; end
                if (sub == 3'd2) begin a.set_scl = 1'b1; a.scl_v = 1'b1; end
                if (sub == 3'd3) begin a.set_sda = 1'b1; a.sda_v = 1'b0; end
            end
            PH_STOP: begin
                if (sub == 3'd0) begin a.set_scl = 1'b1; a.scl_v = 1'b0; end
                if (sub == 3'd1) begin a.set_sda = 1'b1; a.sda_v = 1'b0; end
                if (sub == 3'd2) begin a.set_scl = 1'b1; a.scl_v = 1'b1; end
                if (sub == 3'd3) begin a.set_sda = 1'b1; a.sda_v = 1'b1; end
            end
            PH_WBIT, PH_RBIT: begin
                if (sub == 3'd0) begin a.set_scl = 1'b1; a.scl_v = 1'b0; end
                if (sub == 3'd1) begin
                    a.set_sda = 1'b1;
                    a.sda_v   = (ph == PH_WBIT) ? dbit : 1'b1;
                end
                if (sub == 3'd2) begin a.set_scl = 1'b1; a.scl_v = 1'b1; end
            end
            PH_WACK, PH_RACK: begin
                if (sub == 3'd0) begin a.set_scl = 1'b1; a.scl_v = 1'b0; end
                if (sub == 3'd1) begin
                    a.set_sda = 1'b1;
                    a.sda_v   = (ph == PH_WACK) ? 1'b1 : nk;
                end
                if (sub == 3'd2) begin a.set_scl = 1'b1; a.scl_v = 1'b1; end
                if (sub == 3'd4) begin a.set_scl = 1'b1; a.scl_v = 1'b0; end
            end
            default: a = '{set_scl: 1'b0, scl_v: 1'b1, set_sda: 1'b0, sda_v: 1'b1};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/i2cb_quarter_tick.sv
// Quarter-bit tick divider. Emits one tick every QDIV clocks while 'run' is
// high and restarts its count on 'restart'. Assumes QDIV >= 2.
module i2cb_quarter_tick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int TW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(QDIV - 1);

    logic [TW-1:0] cnt_q;

    // Count clocks within the current quarter period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/i2cb_od_lines.sv
// Open-drain line holders for SCL and SDA. A level of 1 means released and 0
// means pulled low. Both reset to released. Assumes actions come one per step.
module i2cb_od_lines
    import i2cb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      apply,
    input  line_act_t act,
    output logic      scl_oe,
    output logic      sda_oe
);
    logic scl_lvl_q;
    logic sda_lvl_q;

    // Hold the requested level of each line until the next action changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_lvl_q <= 1'b1;
            sda_lvl_q <= 1'b1;
        end else if (apply) begin
            if (act.set_scl) scl_lvl_q <= act.scl_v;
            if (act.set_sda) sda_lvl_q <= act.sda_v;
        end
    end

    assign scl_oe = ~scl_lvl_q;
    assign sda_oe = ~sda_lvl_q;

endmodule

// File: rtl/i2cb_step_ctrl.sv
// Command sequencer. Walks each command through its phases and quarter steps,
// requests line actions, samples SDA, and registers results. Assumes 'tick'
// comes from a divider restarted on acceptance.
module i2cb_step_ctrl
    import i2cb_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NPULSE = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  logic              cmd_nack,
    input  logic              tick,
    input  logic              sda_in,
    output logic              busy,
    output logic              done,
    output logic              restart,
    output logic              apply,
    output line_act_t         act,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ack_out
);
    localparam int MAXN = (BYTE_W > NPULSE) ? BYTE_W : NPULSE;
    localparam int CW   = $clog2(MAXN + 1);
    localparam logic [CW-1:0] LAST_BIT   = CW'(BYTE_W - 1);
    localparam logic [CW-1:0] LAST_PULSE = CW'(NPULSE - 1);

    phase_e            phase_q, nxt_ph, first_ph;
    logic [2:0]        sub_q, nxt_sub;
    logic [CW-1:0]     bit_q, nxt_bit;
    logic [BYTE_W-1:0] wsh_q, rsh_q, rd_q;
    logic              nack_q, ack_smp_q, ack_q, busy_q, done_q;
    logic              valid_op, accept, step, fin;

    // Decode a request into its first phase.
    always_comb begin
        valid_op = 1'b1;
        first_ph = PH_IDLE;
        case (cmd_op)
            OP_RECOVER: first_ph = PH_REL;
            OP_START:   first_ph = PH_START;
            OP_STOP:    first_ph = PH_STOP;
            OP_WRITE:   first_ph = PH_WBIT;
            OP_READ:    first_ph = PH_RBIT;
            default:    valid_op = 1'b0;
        endcase
    end

    assign accept  = cmd_valid && !busy_q && valid_op;
    assign step    = busy_q && tick;
    assign restart = accept;

    // Work out the step that follows the current one, and whether it is the last.
    always_comb begin
        nxt_ph  = phase_q;
        nxt_sub = sub_q + 3'd1;
        nxt_bit = bit_q;
        fin     = 1'b0;
        case (phase_q)
            PH_REL: begin
                nxt_ph  = PH_PULSE;
                nxt_sub = 3'd0;
                nxt_bit = '0;
            end
            PH_PULSE: begin
                if (sub_q == 3'd3) begin
                    nxt_sub = 3'd0;
                    if (bit_q == LAST_PULSE) nxt_ph = PH_STOP;
                    else                     nxt_bit = bit_q + 1'b1;
                end
            end
            PH_START, PH_STOP: begin
                if (sub_q == 3'd3) fin = 1'b1;
            end
            PH_WBIT: begin
                if (sub_q == 3'd3) begin
                    nxt_sub = 3'd0;
                    if (bit_q == LAST_BIT) nxt_ph = PH_WACK;
                    else                   nxt_bit = bit_q + 1'b1;
                end
            end
            PH_RBIT: begin
                if (sub_q == 3'd3) begin
                    nxt_sub = 3'd0;
                    if (bit_q == LAST_BIT) nxt_ph = PH_RACK;
                    else                   nxt_bit = bit_q + 1'b1;
                end
            end
            PH_WACK, PH_RACK: begin
                if (sub_q == 3'd4) fin = 1'b1;
            end
            default: fin = 1'b1;
        endcase
    end

    // Choose the line action that opens the step now beginning.
    always_comb begin
        if (accept) act = step_action(first_ph, 3'd0, cmd_wdata[BYTE_W-1], cmd_nack);
        else        act = step_action(nxt_ph, nxt_sub, wsh_q[BYTE_W-1], nack_q);
    end

    assign apply = accept || (step && !fin);

    // Sequencer state, shift registers, sampling and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            sub_q     <= 3'd0;
            bit_q     <= '0;
            wsh_q     <= '0;
            rsh_q     <= '0;
            rd_q      <= '0;
            nack_q    <= 1'b0;
            ack_smp_q <= 1'b0;
            ack_q     <= 1'b0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                phase_q <= first_ph;
                sub_q   <= 3'd0;
                bit_q   <= '0;
                wsh_q   <= cmd_wdata;
                rsh_q   <= '0;
                nack_q  <= cmd_nack;
            end else if (step) begin
                if (phase_q == PH_WACK && sub_q == 3'd3) ack_smp_q <= sda_in;
                if (phase_q == PH_RBIT && sub_q == 3'd2) rsh_q <= {rsh_q[BYTE_W-2:0], sda_in};
                if (phase_q == PH_WBIT && sub_q == 3'd3) wsh_q <= {wsh_q[BYTE_W-2:0], 1'b0};
                if (fin) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    phase_q <= PH_IDLE;
                    if (phase_q == PH_WACK) ack_q <= ack_smp_q;
                    if (phase_q == PH_RACK) rd_q  <= rsh_q;
                end else begin
                    phase_q <= nxt_ph;
                    sub_q   <= nxt_sub;
                    bit_q   <= nxt_bit;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rd_data = rd_q;
    assign ack_out = ack_q;

endmodule

// File: rtl/i2c_bit_engine.sv
// Top of the I2C bit-level master. Joins the tick divider, the command
// sequencer and the open-drain line holders. Assumes an external pull-up
// on both lines and a target that does not stretch SCL.
module i2c_bit_engine #(
    parameter int QDIV   = 4,
    parameter int BYTE_W = 8,
    parameter int NPULSE = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  logic              cmd_nack,
    input  logic              sda_in,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ack_out,
    output logic              scl_oe,
    output logic              sda_oe
);
    import i2cb_pkg::*;

    logic      quarter_tick;
    logic      tick_restart;
    logic      line_apply;
    line_act_t line_act;

    i2cb_quarter_tick #(.QDIV(QDIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tick_restart),
        .run     (busy),
        .tick    (quarter_tick)
    );

    i2cb_step_ctrl #(.BYTE_W(BYTE_W), .NPULSE(NPULSE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .cmd_nack  (cmd_nack),
        .tick      (quarter_tick),
        .sda_in    (sda_in),
        .busy      (busy),
        .done      (done),
        .restart   (tick_restart),
        .apply     (line_apply),
        .act       (line_act),
        .rd_data   (rd_data),
        .ack_out   (ack_out)
    );

    i2cb_od_lines u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply  (line_apply),
        .act    (line_act),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe)
    );

endmodule

// File: rtl/i2cb_checker.sv
// Protocol checker for the I2C bit engine, bound to every instance of the top.
// Assumes the quarter tick is brought out from the top's divider wire.
module i2cb_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              busy,
    input logic              done,
    input logic              tick,
    input logic [BYTE_W-1:0] rd_data,
    input logic              ack_out,
    input logic              scl_oe,
    input logic              sda_oe
);
    logic take;
    logic bad_op;
    assign take   = cmd_valid && !busy && (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
    assign bad_op = cmd_valid && !busy && ((cmd_op == 3'd0) || (cmd_op > 3'd5));

    AST_LINE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(scl_oe) || !$stable(sda_oe)) |-> ($past(tick) || $past(take))); // R1
    AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |=> !busy); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(scl_oe) && $stable(sda_oe))); // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R3
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data)); // R10
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ack_out)); // R10
    AST_LINES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(scl_oe) && !$stable(sda_oe)) |-> $past(take && cmd_op == 3'd1)); // R10

endmodule

bind i2c_bit_engine i2cb_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .tick      (quarter_tick),
    .rd_data   (rd_data),
    .ack_out   (ack_out),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
);

// File: tb/i2c_bit_engine_test.sv
`timescale 1ns/1ps
module i2c_bit_engine_test;
    localparam int QD = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [7:0] cmd_wdata;
    logic       cmd_nack;
    logic       busy, done, ack_out, scl_oe, sda_oe;
    logic [7:0] rd_data;
    logic       slv_low;
    wire        scl_line = ~scl_oe;
    wire        sda_line = ~sda_oe & ~slv_low;

    always #10 clk = ~clk;

    i2c_bit_engine #(.QDIV(QD)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .sda_in(sda_line),
        .busy(busy), .done(done), .rd_data(rd_data), .ack_out(ack_out),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int nchecks = 0;
    int nerr    = 0;
    int cyc     = 0;
    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Bus observer and simple target model.
    int         rises, starts, stops;
    logic [7:0] cap, cap8, rbyte;
    logic       bit9, ack_low, mode_rd, mode_wr;

    always @(posedge scl_line) begin
        rises++;
        cap = {cap[6:0], sda_line};
        if (rises == 8) cap8 = cap;
        if (rises == 9) bit9 = sda_line;
    end
    always @(negedge scl_line) begin
        if (mode_rd && rises >= 1 && rises < 8) slv_low = ~rbyte[7 - rises];
        else if (mode_rd && rises == 8)         slv_low = 1'b0;
        if (mode_wr && rises == 8)              slv_low = ack_low;
        else if (mode_wr && rises == 9)         slv_low = 1'b0;
    end
    always @(negedge sda_line) if (scl_line === 1'b1) starts++;
    always @(posedge sda_line) if (scl_line === 1'b1) stops++;

    typedef struct {
        logic [2:0] op;
        int         acc;
        int         ticks;
        int         exp_rises;
        int         exp_starts;
        int         exp_stops;
        bit         chk_cap;
        logic [7:0] exp_cap;
        bit         chk_bit9;
        logic       exp_bit9;
        bit         chk_rd;
        logic [7:0] exp_rd;
        bit         chk_ack;
        logic       exp_ack;
        string      rq;
    } item_t;
    item_t sb[$];

    // Driver: issue one command, push its expectations, optionally poke while busy.
    task automatic do_cmd(input logic [2:0] op, input logic [7:0] wd, input logic nk,
                          input logic [7:0] tbyte, input logic alow, input int poke_at);
        item_t it;
        while (busy) @(negedge clk);
        @(negedge clk);
        rises = 0; starts = 0; stops = 0; cap = 8'h00;
        mode_rd = (op == 3'd5); mode_wr = (op == 3'd4);
        rbyte = tbyte; ack_low = alow; slv_low = 1'b0;
        cmd_op = op; cmd_wdata = wd; cmd_nack = nk; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        it.op = op; it.acc = cyc;
        it.chk_cap = 0; it.chk_bit9 = 0; it.chk_rd = 0; it.chk_ack = 0;
        it.exp_cap = 8'h00; it.exp_bit9 = 1'b0; it.exp_rd = 8'h00; it.exp_ack = 1'b0;
        it.exp_rises = -1; it.exp_starts = 0; it.exp_stops = 0;
        case (op)
            3'd1: begin it.ticks = 41; it.exp_rises = 10; it.exp_stops = 1;
                        it.chk_cap = 1; it.exp_cap = 8'hFF; it.rq = "R9"; end
            3'd2: begin it.ticks = 4; it.exp_starts = 1; it.rq = "R5"; end
            3'd3: begin it.ticks = 4; it.exp_stops = 1; it.rq = "R6"; end
            3'd4: begin it.ticks = 37; it.exp_rises = 9; it.chk_cap = 1; it.exp_cap = wd;
                        it.chk_ack = 1; it.exp_ack = ~alow; it.rq = "R7"; end
            default: begin it.ticks = 37; it.exp_rises = 9; it.chk_cap = 1; it.exp_cap = tbyte;
                        it.chk_bit9 = 1; it.exp_bit9 = nk; it.chk_rd = 1; it.exp_rd = tbyte;
                        it.rq = "R8"; end
        endcase
        sb.push_back(it);
        chk(busy === 1'b1, "R3", "busy after accept", busy, 1);
        if (op == 3'd5) slv_low = ~tbyte[7];
        if (poke_at > 0) begin
            repeat (poke_at) @(negedge clk);
            cmd_op = 3'd2; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
    endtask

    // Monitor: pop and compare each result on its done cycle.
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        item_t it;
        if (rst_n === 1'b1) begin
            if (prev_done) chk(done === 1'b0, "R4", "done width", done, 0);
            if (done === 1'b1) begin
                if (sb.size() == 0) begin
                    chk(0, "R3", "done without command", 1, 0);
                end else begin
                    it = sb.pop_front();
                    chk((cyc - it.acc) == it.ticks * QD, "R1 R4", "duration clocks",
                        cyc - it.acc, it.ticks * QD);
                    chk(starts == it.exp_starts, it.rq, "start conditions", starts, it.exp_starts);
                    chk(stops == it.exp_stops, it.rq, "stop conditions", stops, it.exp_stops);
                    if (it.exp_rises >= 0)
                        chk(rises == it.exp_rises, it.rq, "scl rising edges", rises, it.exp_rises);
                    if (it.chk_cap)  chk(cap8 === it.exp_cap, it.rq, "bits on bus", cap8, it.exp_cap);
                    if (it.chk_bit9) chk(bit9 === it.exp_bit9, it.rq, "master ack bit", bit9, it.exp_bit9);
                    if (it.chk_rd)   chk(rd_data === it.exp_rd, it.rq, "rd_data", rd_data, it.exp_rd);
                    if (it.chk_ack)  chk(ack_out === it.exp_ack, it.rq, "ack_out", ack_out, it.exp_ack);
                end
            end
            prev_done = done;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
        $finish;
    end

    initial begin
        logic s_scl, s_sda;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_wdata = 8'h00; cmd_nack = 1'b0;
        slv_low = 1'b0; mode_rd = 1'b0; mode_wr = 1'b0; rbyte = 8'h00; ack_low = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(busy === 1'b0 && done === 1'b0, "R11", "busy/done", {busy, done}, 0);
        chk(scl_oe === 1'b0 && sda_oe === 1'b0, "R11", "lines released", {scl_oe, sda_oe}, 0);
        chk(rd_data === 8'h00 && ack_out === 1'b0, "R11", "results", {rd_data, ack_out}, 0);

        do_cmd(3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 0);   // recover
        do_cmd(3'd2, 8'h00, 1'b0, 8'h00, 1'b0, 0);   // start
        do_cmd(3'd4, 8'hA5, 1'b0, 8'h00, 1'b1, 0);   // write, ACK
        do_cmd(3'd4, 8'h3C, 1'b0, 8'h00, 1'b0, 0);   // write, NACK
        do_cmd(3'd2, 8'h00, 1'b0, 8'h00, 1'b0, 0);   // repeated start
        do_cmd(3'd4, 8'h5A, 1'b0, 8'h00, 1'b1, 0);
        do_cmd(3'd5, 8'h00, 1'b0, 8'hC3, 1'b0, 0);   // read, ACK
        do_cmd(3'd5, 8'h00, 1'b1, 8'h96, 1'b0, 0);   // read, NACK
        do_cmd(3'd3, 8'h00, 1'b0, 8'h00, 1'b0, 0);   // stop
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        // R10: results held across a command that does not produce them
        chk(rd_data === 8'h96, "R10", "rd_data held", rd_data, 8'h96);
        chk(ack_out === 1'b0, "R10", "ack_out held", ack_out, 0);

        // R2: undefined codes are ignored
        s_scl = scl_oe; s_sda = sda_oe;
        cmd_op = 3'd6; cmd_valid = 1'b1; @(negedge clk);
        cmd_op = 3'd0; @(negedge clk);
        cmd_op = 3'd7; @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk(busy === 1'b0 && done === 1'b0, "R2", "busy/done after bad code", {busy, done}, 0);
            chk(scl_oe === s_scl && sda_oe === s_sda, "R2", "lines after bad code",
                {scl_oe, sda_oe}, {s_scl, s_sda});
            @(negedge clk);
        end

        // R3: a request during a running write is ignored
        do_cmd(3'd2, 8'h00, 1'b0, 8'h00, 1'b0, 0);
        do_cmd(3'd4, 8'h81, 1'b0, 8'h00, 1'b1, 20);
        do_cmd(3'd3, 8'h00, 1'b0, 8'h00, 1'b0, 0);
        while (busy) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(sb.size() == 0, "R3", "outstanding results", sb.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
        $finish;
    end

endmodule